// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block is the column-address and read-timing engine of a four-bank synchronous DRAM model. A load-mode command programs how many beats a burst carries, whether beats walk the column in a wrapped sequential order or an XOR interleaved order, and how many clocks pass between a read command and its first data. Each accepted read or write command then produces one column address per clock for the length of the burst, together with the bank that the command selected.

A terminate command or a fresh read or write may cut the running burst on any cycle. Read beats feed a short delay line, so that a read-data-valid strobe follows each read beat by the programmed latency. Beats already in that line still drain after a terminate. Mode settings that cannot be honoured are refused and flagged for one cycle.

Top module: `sdram_col_seq`

## Requirements
- R1: While and after reset, `beat_vld_o`, `rd_vld_o` and `mode_err_o` are low. The mode register resets to burst length 1, sequential order and read latency 2.
- R2: A read (`cmd_i`=1) or write (`cmd_i`=2) sampled at a clock edge makes `beat_vld_o` high from that edge on. `bank_o` holds the command's bank for the whole burst. For a burst length BL that is not full page, exactly BL beats are issued and `beat_vld_o` then falls.
- R3: In sequential order, the low log2(BL) bits of beat n equal the starting low bits plus n, modulo BL. The upper column bits equal those of the start column.
- R4: In interleaved order, the low log2(BL) bits of beat n equal the starting low bits XOR n. The upper bits are unchanged.
- R5: Full page (length code 7, sequential only) counts the 9-bit column up by one per beat and wraps from 511 to 0. It runs until a terminate or a new read or write arrives.
- R6: A load-mode command (`cmd_i`=4) takes `mode_bl_i` (0→1, 1→2, 2→4, 3→8, 7→full page), `mode_il_i` (1 = interleaved) and `mode_lat3_i` (0→2, 1→3). Reserved length codes 4 to 6, and interleaved order with full page, leave the mode unchanged. In that case `mode_err_o` is high for the following cycle only.
- R7: For a read command sampled at the edge closing cycle c, `rd_vld_o` is high in cycle c+L+n for beat n, where L is the programmed latency. Write beats never raise `rd_vld_o`.
- R8: A terminate (`cmd_i`=3) sampled at an edge ends the burst, so no beat is issued after that edge. Read beats already issued still produce their `rd_vld_o` pulses.
- R9: A read or write that arrives during a burst replaces it at the next edge. The new bank and start column appear at once, and the beat count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Command: 0 no-op, 1 read, 2 write, 3 terminate, 4 load mode, others no-op |
| bank_i | input | 2 | Bank select of a read or write |
| col_i | input | 9 | Start column of a read or write |
| mode_bl_i | input | 3 | Burst length code for load mode |
| mode_il_i | input | 1 | Burst order for load mode, 1 = interleaved |
| mode_lat3_i | input | 1 | Read latency for load mode, 1 = three clocks |
| beat_vld_o | output | 1 | A burst beat is issued this cycle |
| bank_o | output | 2 | Bank of the current beat |
| col_o | output | 9 | Column of the current beat |
| rd_vld_o | output | 1 | Read data valid, delayed by the latency |
| mode_err_o | output | 1 | Previous load mode was refused |

## Verification
The hardest situation to reach is a burst cut while read beats are still in the latency line. This can be a terminate or a new command landing on the last beat, or a full-page run wrapping past column 511 just as a latency change or a refused mode load arrives. Directed sequences reach each of these on purpose: a full-page burst started at column 510, a terminate issued under latency 3, and illegal mode loads followed by a burst whose length exposes the retained mode. A long random phase then mixes all commands with random mode fields, so interruptions land on every beat position.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;
  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_RD    = 3'd1,
    CMD_WR    = 3'd2,
    CMD_TERM  = 3'd3,
    CMD_LMODE = 3'd4
  } cmd_e;

  localparam logic [2:0] BL_FULL = 3'd7;
endpackage

// File: rtl/sdram_col_mode.sv
module sdram_col_mode #(
  parameter int COL_W = 9,
  parameter int LAT_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_i,
  input  logic [2:0]       bl_i,
  input  logic             il_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic [COL_W-1:0] mask_o,
  output logic             il_o,
  output logic             full_o,
  output logic [LAT_W-1:0] lat_o,
  output logic             err_o
);
  import sdram_col_pkg::*;

  logic [2:0]       bl_q, bl_d;
  logic             il_q, il_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic             err_q, err_d;
  logic             legal;

  always_comb begin
    legal = ((bl_i <= 3'd3) || (bl_i == BL_FULL)) && !(il_i && (bl_i == BL_FULL));
    bl_d  = bl_q;
    il_d  = il_q;
    lat_d = lat_q;
    err_d = ld_i && !legal;
    if (ld_i && legal) begin
      bl_d  = bl_i;
      il_d  = il_i;
      lat_d = lat_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_q  <= '0;
      il_q  <= 1'b0;
      lat_q <= '0;
      err_q <= 1'b0;
    end else begin
      bl_q  <= bl_d;
      il_q  <= il_d;
      lat_q <= lat_d;
      err_q <= err_d;
    end
  end

  assign full_o = (bl_q == BL_FULL);
  assign mask_o = full_o ? {COL_W{1'b1}} : ((COL_W'(1) << bl_q) - COL_W'(1));
  assign il_o   = il_q;
  assign lat_o  = lat_q;
  assign err_o  = err_q;

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_i && !legal) |=> ($stable(bl_q) && $stable(il_q) && $stable(lat_q) && err_o));

  // R6
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> !err_o);
endmodule

// File: rtl/sdram_col_burst.sv
module sdram_col_burst #(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic              term_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [COL_W-1:0]  mask_i,
  input  logic              il_i,
  input  logic              full_i,
  output logic              act_o,
  output logic              rd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col_o
);
  logic              act_q, act_d;
  logic [COL_W-1:0]  cnt_q, cnt_d;
  logic              rd_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  base_q, mask_q;
  logic              il_q, full_q;
  logic              last;

  assign last = !full_q && (cnt_q == mask_q);

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (start_i) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (term_i) begin
      act_d = 1'b0;
    end else if (act_q) begin
      if (last) act_d = 1'b0;
      else      cnt_d = cnt_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      bank_q <= '0;
      base_q <= '0;
      mask_q <= '0;
      il_q   <= 1'b0;
      full_q <= 1'b0;
    end else if (start_i) begin
      rd_q   <= rd_i;
      bank_q <= bank_i;
      base_q <= col_i;
      mask_q <= mask_i;
      il_q   <= il_i;
      full_q <= full_i;
    end
  end

  assign act_o  = act_q;
  assign rd_o   = rd_q;
  assign bank_o = bank_q;
  assign col_o  = il_q ? (base_q ^ cnt_q)
                       : ((base_q & ~mask_q) | ((base_q + cnt_q) & mask_q));

  // R2
  beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !full_q) |-> (cnt_q <= mask_q));

  // R8
  term_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_i && !start_i) |=> !act_o);

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (act_o && cnt_q == '0 && bank_o == $past(bank_i) && col_o == $past(col_i)));
endmodule

// File: rtl/sdram_col_rdpipe.sv
module sdram_col_rdpipe #(
  parameter int LAT_MIN = 2,
  parameter int LAT_W   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_rd_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             rd_vld_o
);
  localparam int DEPTH = LAT_MIN - 1 + (1 << LAT_W) - 1;

  logic [DEPTH-1:0] pipe_q;

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[0] <= 1'b0;
        else        pipe_q[0] <= beat_rd_i;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= 1'b0;
        else        pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign rd_vld_o = pipe_q[LAT_MIN - 2 + int'(lat_i)];

  // R7
  lat_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_i == '0) |-> (rd_vld_o == $past(beat_rd_i)));

  // R7
  lat_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_i == LAT_W'(1) && $past(beat_rd_i, 2)) |-> rd_vld_o);
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq #(
  parameter int COL_W   = 9,
  parameter int BANK_W  = 2,
  parameter int LAT_MIN = 2,
  parameter int LAT_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [2:0]        mode_bl_i,
  input  logic              mode_il_i,
  input  logic [LAT_W-1:0]  mode_lat3_i,
  output logic              beat_vld_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col_o,
  output logic              rd_vld_o,
  output logic              mode_err_o
);
  import sdram_col_pkg::*;

  logic             start, is_rd, term, ld;
  logic [COL_W-1:0] mask;
  logic             il, full, act, rd;
  logic [LAT_W-1:0] lat;

  assign is_rd = (cmd_i == CMD_RD);
  assign start = is_rd || (cmd_i == CMD_WR);
  assign term  = (cmd_i == CMD_TERM);
  assign ld    = (cmd_i == CMD_LMODE);

  sdram_col_mode #(.COL_W(COL_W), .LAT_W(LAT_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .ld_i(ld), .bl_i(mode_bl_i), .il_i(mode_il_i),
    .lat_i(mode_lat3_i), .mask_o(mask), .il_o(il), .full_o(full),
    .lat_o(lat), .err_o(mode_err_o)
  );

  sdram_col_burst #(.COL_W(COL_W), .BANK_W(BANK_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rd_i(is_rd), .term_i(term),
    .bank_i(bank_i), .col_i(col_i), .mask_i(mask), .il_i(il), .full_i(full),
    .act_o(act), .rd_o(rd), .bank_o(bank_o), .col_o(col_o)
  );

  sdram_col_rdpipe #(.LAT_MIN(LAT_MIN), .LAT_W(LAT_W)) u_rdpipe (
    .clk(clk), .rst_n(rst_n), .beat_rd_i(act && rd), .lat_i(lat),
    .rd_vld_o(rd_vld_o)
  );

  assign beat_vld_o = act;
endmodule

// File: tb/sdram_col_seq_tb.sv
module sdram_col_seq_tb;
  import sdram_col_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] cmd_i;
  logic [1:0] bank_i;
  logic [8:0] col_i;
  logic [2:0] mode_bl_i;
  logic       mode_il_i;
  logic       mode_lat3_i;
  logic       beat_vld_o, rd_vld_o, mode_err_o;
  logic [1:0] bank_o;
  logic [8:0] col_o;

  always #5 clk = ~clk;

  sdram_col_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i), .col_i(col_i),
    .mode_bl_i(mode_bl_i), .mode_il_i(mode_il_i), .mode_lat3_i(mode_lat3_i),
    .beat_vld_o(beat_vld_o), .bank_o(bank_o), .col_o(col_o),
    .rd_vld_o(rd_vld_o), .mode_err_o(mode_err_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic [2:0] m_bl; logic m_il, m_lat, m_err;
  logic b_act, b_rd, b_il, b_full; logic [1:0] b_bank;
  logic [8:0] b_base, b_cnt, b_mask;
  logic p0, p1, was_act;
  logic [2:0] last_cmd;
  int since_term;

  function automatic logic [8:0] mask_of(input logic [2:0] bl);
    return (bl == 3'd7) ? 9'h1FF : ((9'd1 << bl) - 9'd1);
  endfunction

  function automatic logic [8:0] exp_col();
    if (b_il) return b_base ^ b_cnt;
    return (b_base & ~b_mask) | ((b_base + b_cnt) & b_mask);
  endfunction

  function automatic string beat_tag();
    if (last_cmd == 3'd3) return "R8";
    if ((last_cmd == 3'd1 || last_cmd == 3'd2) && was_act) return "R9";
    if (!b_act) return "R2";
    if (b_full) return "R5";
    if (b_il) return "R4";
    return "R3";
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] c, input logic [1:0] bk, input logic [8:0] cl,
                      input logic [2:0] bl, input logic il, input logic lat);
    logic legal;
    @(negedge clk);
    chk(beat_vld_o == b_act, beat_tag(), "beat_vld", beat_vld_o, b_act);
    if (b_act) begin
      chk(col_o == exp_col(), beat_tag(), "col", col_o, exp_col());
      chk(bank_o == b_bank, "R2", "bank", bank_o, b_bank);
    end
    chk(rd_vld_o == (m_lat ? p1 : p0), (since_term < 4) ? "R8" : "R7", "rd_vld",
        rd_vld_o, m_lat ? p1 : p0);
    chk(mode_err_o == m_err, "R6", "mode_err", mode_err_o, m_err);
    cmd_i = c; bank_i = bk; col_i = cl; mode_bl_i = bl; mode_il_i = il; mode_lat3_i = lat;
    // next state
    p1 = p0; p0 = b_act & b_rd;
    was_act = b_act;
    if (c == 3'd1 || c == 3'd2) begin
      b_act = 1; b_rd = (c == 3'd1); b_bank = bk; b_base = cl; b_cnt = 0;
      b_mask = mask_of(m_bl); b_il = m_il; b_full = (m_bl == 3'd7);
    end else if (c == 3'd3) b_act = 0;
    else if (b_act) begin
      if (!b_full && b_cnt == b_mask) b_act = 0;
      else b_cnt = b_cnt + 9'd1;
    end
    legal = (bl <= 3'd3 || bl == 3'd7) && !(il && bl == 3'd7);
    m_err = (c == 3'd4) && !legal;
    if (c == 3'd4 && legal) begin m_bl = bl; m_il = il; m_lat = lat; end
    last_cmd = c;
    since_term = (c == 3'd3) ? 0 : since_term + 1;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) step(3'd0, 2'd0, 9'd0, 3'd0, 1'b0, 1'b0);
  endtask

  task automatic ldm(input logic [2:0] bl, input logic il, input logic lat);
    step(3'd4, 2'd0, 9'd0, bl, il, lat);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; cmd_i = 0; bank_i = 0; col_i = 0; mode_bl_i = 0; mode_il_i = 0; mode_lat3_i = 0;
    m_bl = 0; m_il = 0; m_lat = 0; m_err = 0;
    b_act = 0; b_rd = 0; b_il = 0; b_full = 0; b_bank = 0; b_base = 0; b_cnt = 0; b_mask = 0;
    p0 = 0; p1 = 0; was_act = 0; last_cmd = 0; since_term = 100;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(beat_vld_o == 0, "R1", "beat_vld in reset", beat_vld_o, 0);
    chk(rd_vld_o == 0, "R1", "rd_vld in reset", rd_vld_o, 0);
    chk(mode_err_o == 0, "R1", "mode_err in reset", mode_err_o, 0);
    rst_n = 1;
    nops(2);
    // R1 default mode: one beat, latency 2
    step(3'd1, 2'd2, 9'h105, 3'd0, 1'b0, 1'b0);
    nops(5);
    // R3 sequential wrap, BL8
    ldm(3'd3, 1'b0, 1'b0);
    step(3'd1, 2'd1, 9'h00D, 3'd0, 1'b0, 1'b0);
    nops(12);
    // R4 interleaved BL8 and BL4, latency 3
    ldm(3'd3, 1'b1, 1'b1);
    step(3'd1, 2'd3, 9'h0AB, 3'd0, 1'b0, 1'b0);
    nops(12);
    ldm(3'd2, 1'b1, 1'b1);
    step(3'd2, 2'd0, 9'h036, 3'd0, 1'b0, 1'b0);
    nops(6);
    // R6 illegal loads keep interleaved BL4
    ldm(3'd7, 1'b1, 1'b0);
    ldm(3'd5, 1'b0, 1'b0);
    nops(1);
    step(3'd1, 2'd1, 9'h011, 3'd0, 1'b0, 1'b0);
    nops(8);
    // R5 full page wrap, then R8 terminate under latency 3
    ldm(3'd7, 1'b0, 1'b1);
    step(3'd1, 2'd2, 9'h1FE, 3'd0, 1'b0, 1'b0);
    nops(6);
    step(3'd3, 2'd0, 9'd0, 3'd0, 1'b0, 1'b0);
    nops(6);
    // R9 interrupt a BL8 read with a write
    ldm(3'd3, 1'b0, 1'b0);
    step(3'd1, 2'd0, 9'h040, 3'd0, 1'b0, 1'b0);
    nops(3);
    step(3'd2, 2'd3, 9'h17C, 3'd0, 1'b0, 1'b0);
    nops(3);
    step(3'd1, 2'd1, 9'h0F0, 3'd0, 1'b0, 1'b0);
    nops(10);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [2:0] c;
      r = $urandom % 100;
      c = (r < 50) ? 3'd0 : (r < 64) ? 3'd1 : (r < 76) ? 3'd2 :
          (r < 84) ? 3'd3 : (r < 92) ? 3'd4 : 3'(5 + ($urandom % 3));
      step(c, 2'($urandom), 9'($urandom), 3'($urandom), 1'($urandom), 1'($urandom));
    end
    nops(6);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule